// File: doc/BRIEF.md
# Color Subcarrier Phase Oscillator

This block is a numerically controlled oscillator that gives a standard-definition video encoder the phase of its color subcarrier. On every pixel clock cycle that is enabled, a 32-bit phase register grows by a programmable frequency word and wraps modulo 2^32. The word equals round(f_sub / f_pix × 2^32), with both frequencies counted in cycles per video line. Some example values: 0x2A098ACB gives 283.7516 subcarrier cycles over 1728 pixel clocks, 0x21F07C1F gives 227.5 over 1716, and 0x28A33BB2 gives 274.304 over 1728. The top bits of the phase go to a sine lookup that lies outside this block.

Control logic writes the frequency word one byte at a time into a shadow copy. The whole shadow copy becomes the working word in a single step at a line boundary, so the oscillator never runs on a partly written word.

A two-bit schedule selects when the phase is forced back to zero:
- at every second line start,
- at every fourth field start,
- at every eighth field start, or
- never on its own.

An external strobe also clears the phase, in every schedule.

Top module: `sc_phase_nco`

## Requirements
- R1: After the synchronous reset, `phase` and `phase_top` read 0. The working and shadow words both hold 0x2A098ACB, and both the line and field counters are at zero.
- R2: On a cycle with `pix_en` high and no clear, `phase` becomes the old phase plus the working word, modulo 2^32, on the next clock. With `pix_en` low it holds its value.
- R3: A cycle with `wb_en` high writes `wb_data` into byte `wb_sel` of the shadow word. `wb_sel` = 0 is bits 7:0 and `wb_sel` = 3 is bits 31:24. Such a write does not change the step that `phase` advances by.
- R4: On a cycle with `line_start` high, the working word takes the shadow word as it stood before that edge. The new step applies from the next cycle on. A byte written in that same cycle waits in the shadow for the following line start.
- R5: A cycle with `sched_wr` high loads `sched_in` into the schedule register, which takes effect from the next cycle. After reset the schedule register is 2'b10.
- R6: With schedule 2'b01, the line counter counts `line_start` modulo 2 from reset. Every `line_start` that finds the counter at 1 makes `phase` read 0 on the next clock.
- R7: With schedule 2'b10, the field counter counts `field_start` modulo 8 from reset. Every `field_start` that finds the counter at 7 makes `phase` read 0 on the next clock.
- R8: With schedule 2'b11, every `field_start` that finds the field counter at 3 or 7 makes `phase` read 0 on the next clock.
- R9: `ext_clr` makes `phase` read 0 on the next clock under any schedule. With schedule 2'b00, line and field strobes never clear the phase.
- R10: `phase_top` always equals the upper 10 bits of `phase`.
- R11: A clear takes priority over the add: when a clear and `pix_en` fall in the same cycle, the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Advance the phase this cycle |
| wb_en | input | 1 | Write one byte of the shadow frequency word |
| wb_sel | input | 2 | Byte index, 0 = least significant |
| wb_data | input | 8 | Byte value |
| sched_wr | input | 1 | Load a new clear schedule |
| sched_in | input | 2 | Schedule: 00 external only, 01 two lines, 10 eight fields, 11 four fields |
| line_start | input | 1 | One-cycle strobe at each line start |
| field_start | input | 1 | One-cycle strobe at each field start |
| ext_clr | input | 1 | External phase clear pulse |
| phase | output | 32 | Subcarrier phase |
| phase_top | output | 10 | Upper phase bits for the sine lookup |

## Verification
The hardest case to reach is a byte write that lands in the same cycle as a line start. In that case the previous shadow word is committed, and a word mixing old and new bytes appears only at the next line start. The stimulus creates this case on purpose by writing a single high byte on a line-start cycle, then issuing a second line start.

The line and field counters run in every schedule, so the point at which a clear falls depends on the whole strobe history since reset. The stimulus switches schedules partway through the count, and the bench's own counters predict when each clear should happen. The bench checks the phase every cycle, and it also checks that the phase is exactly zero after each clear it predicts.

// File: rtl/sc_nco_pkg.sv
package sc_nco_pkg;

  typedef enum logic [1:0] {
    SCHED_EXT_ONLY   = 2'b00,
    SCHED_TWO_LINES  = 2'b01,
    SCHED_EIGHT_FLDS = 2'b10,
    SCHED_FOUR_FLDS  = 2'b11
  } sched_e;

  localparam logic [31:0] WORD_625_LINE = 32'h2A09_8ACB;

endpackage

// File: rtl/sc_freq_word.sv
module sc_freq_word #(
  parameter int            PH_W     = 32,
  parameter logic [PH_W-1:0] DEF_WORD = PH_W'(32'h2A09_8ACB)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wb_en,
  input  logic [$clog2(PH_W/8)-1:0] wb_sel,
  input  logic [7:0]                wb_data,
  input  logic                      line_start,
  output logic [PH_W-1:0]           word
);
  localparam int NBYTES = PH_W / 8;
  localparam int SEL_W  = $clog2(NBYTES);

  logic [PH_W-1:0] shadow;

  // one staging byte per lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        shadow[b*8 +: 8] <= DEF_WORD[b*8 +: 8];
      else if (wb_en && (wb_sel == SEL_W'(b)))
        shadow[b*8 +: 8] <= wb_data;
    end
  end

  // atomic commit of the whole word at a line boundary
  always_ff @(posedge clk) begin
    if (rst)             word <= DEF_WORD;
    else if (line_start) word <= shadow;
  end

  a_r4_word_held: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(word));
  a_r4_word_commit: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (word == $past(shadow)));

endmodule

// File: rtl/sc_reset_sched.sv
module sc_reset_sched
  import sc_nco_pkg::*;
#(
  parameter int LINE_PERIOD = 2,
  parameter int FLD_LONG    = 8,
  parameter int FLD_SHORT   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sched_wr,
  input  logic [1:0] sched_in,
  input  logic       line_start,
  input  logic       field_start,
  input  logic       ext_clr,
  output logic       zero_req
);
  localparam int LW = (LINE_PERIOD > 1) ? $clog2(LINE_PERIOD) : 1;
  localparam int FW = (FLD_LONG > 1) ? $clog2(FLD_LONG) : 1;
  localparam int SW = (FLD_SHORT > 1) ? $clog2(FLD_SHORT) : 1;

  sched_e        mode_q;
  logic [LW-1:0] line_cnt;
  logic [FW-1:0] fld_cnt;
  logic          line_wrap, fld_long_wrap, fld_short_wrap;

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= SCHED_EIGHT_FLDS;
    else if (sched_wr) mode_q <= sched_e'(sched_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
    end else if (line_start) begin
      line_cnt <= line_wrap ? '0 : line_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_cnt <= '0;
    end else if (field_start) begin
      fld_cnt <= fld_long_wrap ? '0 : fld_cnt + 1'b1;
    end
  end

  assign line_wrap      = (line_cnt == LW'(LINE_PERIOD - 1));
  assign fld_long_wrap  = (fld_cnt == FW'(FLD_LONG - 1));
  assign fld_short_wrap = (fld_cnt[SW-1:0] == SW'(FLD_SHORT - 1));

  always_comb begin
    zero_req = ext_clr;
    unique case (mode_q)
      SCHED_TWO_LINES:  if (line_start  && line_wrap)      zero_req = 1'b1;
      SCHED_EIGHT_FLDS: if (field_start && fld_long_wrap)  zero_req = 1'b1;
      SCHED_FOUR_FLDS:  if (field_start && fld_short_wrap) zero_req = 1'b1;
      default:          ;
    endcase
  end

  a_r9_ext_always: assert property (@(posedge clk) disable iff (rst)
    ext_clr |-> zero_req);
  a_r9_idle_mode_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SCHED_EXT_ONLY) && !ext_clr |-> !zero_req);
  a_r6_line_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SCHED_TWO_LINES) && !line_start && !ext_clr |-> !zero_req);

endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
  parameter int PH_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_en,
  input  logic            zero_req,
  input  logic [PH_W-1:0] word,
  output logic [PH_W-1:0] acc
);

  always_ff @(posedge clk) begin
    if (rst)           acc <= '0;
    else if (zero_req) acc <= '0;
    else if (pix_en)   acc <= acc + word;
  end

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    zero_req |=> (acc == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    pix_en && !zero_req |=> (acc == $past(acc) + $past(word)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_en && !zero_req |=> $stable(acc));

endmodule

// File: rtl/sc_phase_nco.sv
module sc_phase_nco
  import sc_nco_pkg::*;
#(
  parameter int          PH_W        = 32,
  parameter int          TOP_W       = 10,
  parameter int          LINE_PERIOD = 2,
  parameter int          FLD_LONG    = 8,
  parameter int          FLD_SHORT   = 4,
  parameter logic [31:0] DEF_WORD    = WORD_625_LINE
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pix_en,
  input  logic                      wb_en,
  input  logic [$clog2(PH_W/8)-1:0] wb_sel,
  input  logic [7:0]                wb_data,
  input  logic                      sched_wr,
  input  logic [1:0]                sched_in,
  input  logic                      line_start,
  input  logic                      field_start,
  input  logic                      ext_clr,
  output logic [PH_W-1:0]           phase,
  output logic [TOP_W-1:0]          phase_top
);
  logic [PH_W-1:0] word;
  logic            zero_req;

  sc_freq_word #(.PH_W(PH_W), .DEF_WORD(PH_W'(DEF_WORD))) u_word (
    .clk(clk), .rst(rst), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_data(wb_data), .line_start(line_start), .word(word)
  );

  sc_reset_sched #(
    .LINE_PERIOD(LINE_PERIOD), .FLD_LONG(FLD_LONG), .FLD_SHORT(FLD_SHORT)
  ) u_sched (
    .clk(clk), .rst(rst), .sched_wr(sched_wr), .sched_in(sched_in),
    .line_start(line_start), .field_start(field_start),
    .ext_clr(ext_clr), .zero_req(zero_req)
  );

  sc_phase_acc #(.PH_W(PH_W)) u_acc (
    .clk(clk), .rst(rst), .pix_en(pix_en), .zero_req(zero_req),
    .word(word), .acc(phase)
  );

  assign phase_top = phase[PH_W-1 -: TOP_W];

  a_r10_top_slice: assert property (@(posedge clk) disable iff (rst)
    phase_top == phase[PH_W-1 -: TOP_W]);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (phase == '0));

endmodule

// File: tb/sc_phase_nco_bench.sv
module sc_phase_nco_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 0, wb_en = 0, sched_wr = 0;
  logic        line_start = 0, field_start = 0, ext_clr = 0;
  logic [1:0]  wb_sel = 0, sched_in = 0;
  logic [7:0]  wb_data = 0;
  logic [31:0] phase;
  logic [9:0]  phase_top;

  always #10 clk = ~clk; // 50 MHz

  sc_phase_nco u_sc_phase_nco (
    .clk(clk), .rst(rst), .pix_en(pix_en), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_data(wb_data), .sched_wr(sched_wr), .sched_in(sched_in),
    .line_start(line_start), .field_start(field_start), .ext_clr(ext_clr),
    .phase(phase), .phase_top(phase_top)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "R2";

  // behavioural reference
  bit [31:0] m_phase, m_word;
  bit [7:0]  m_sh[4];
  int        m_mode, m_lines, m_fields;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_word = 32'h2A098ACB;
    m_sh[0] = 8'hCB; m_sh[1] = 8'h8A; m_sh[2] = 8'h09; m_sh[3] = 8'h2A;
    m_mode = 2; m_lines = 0; m_fields = 0;
  endtask

  task automatic step(bit en, bit ls = 0, bit fs = 0, bit ext = 0,
                      bit wr = 0, int sel = 0, int data = 0,
                      bit mw = 0, int md = 0);
    bit    clr;
    string why;
    pix_en = en; line_start = ls; field_start = fs; ext_clr = ext;
    wb_en = wr; wb_sel = 2'(sel); wb_data = 8'(data);
    sched_wr = mw; sched_in = 2'(md);
    @(posedge clk);
    clr = 0; why = "";
    if (ext) begin clr = 1; why = "R9"; end
    else if (m_mode == 1 && ls && (m_lines % 2) == 1) begin clr = 1; why = "R6"; end
    else if (m_mode == 2 && fs && (m_fields % 8) == 7) begin clr = 1; why = "R7"; end
    else if (m_mode == 3 && fs && (m_fields % 4) == 3) begin clr = 1; why = "R8"; end
    if (clr) m_phase = 0;
    else if (en) m_phase = m_phase + m_word;
    if (ls) m_word = {m_sh[3], m_sh[2], m_sh[1], m_sh[0]};
    if (wr) m_sh[sel] = 8'(data);
    if (ls) m_lines++;
    if (fs) m_fields++;
    if (mw) m_mode = md;
    @(negedge clk);
    check(cur_tag, "phase", phase, m_phase);
    check("R10", "phase_top", 32'(phase_top), 32'(m_phase[31:22]));
    if (clr) check(why, "phase zero after clear", phase, 32'h0);
    if (clr && en) check("R11", "clear beats add", phase, 32'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pix_en = 0; line_start = 0; field_start = 0; ext_clr = 0;
    wb_en = 0; sched_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1", "phase after reset", phase, 32'h0);
    check("R1", "phase_top after reset", 32'(phase_top), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit [31:0] held;
    do_reset();
    // R1/R5: default step and default eight-field schedule
    cur_tag = "R1";
    step(1);
    check("R1", "default step", phase, 32'h2A098ACB);
    cur_tag = "R5";
    for (int i = 0; i < 8; i++) begin
      step(1); step(1); step(1, 0, 1);
    end
    check("R5", "default schedule clears at 8th field", phase, 32'h0);

    // R2: irregular enable, no periodic clears
    cur_tag = "R2";
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 40; i++) step((i % 3) != 0);
    held = phase;
    for (int i = 0; i < 5; i++) step(0);
    check("R2", "hold with enable low", phase, held);

    // R3: byte writes do not change the step
    cur_tag = "R3";
    step(1, 0, 0, 0, 1, 0, 'h1F);
    step(1, 0, 0, 0, 1, 1, 'h7C);
    step(1, 0, 0, 0, 1, 2, 'hF0);
    held = phase;
    step(1, 0, 0, 0, 1, 3, 'h21);
    check("R3", "step unchanged after writes", phase - held, 32'h2A098ACB);
    for (int i = 0; i < 6; i++) step(1);

    // R4: commit at line start, then collision of write and line start
    cur_tag = "R4";
    step(1, 1);
    held = phase;
    step(1);
    check("R4", "new step after line start", phase - held, 32'h21F07C1F);
    for (int i = 0; i < 5; i++) step(1);
    step(1, 1, 0, 0, 1, 3, 'h28);
    held = phase;
    step(1);
    check("R4", "same-cycle write not committed", phase - held, 32'h21F07C1F);
    step(1, 1);
    held = phase;
    step(1);
    check("R4", "mixed word at next line start", phase - held, 32'h28F07C1F);

    // R6: every second line
    cur_tag = "R6";
    step(1, 0, 0, 0, 0, 0, 0, 1, 1);
    for (int l = 0; l < 7; l++) begin
      for (int i = 0; i < 11; i++) step(i != 4);
      step(1, 1);
    end

    // R7: eight fields, with lines interleaved
    cur_tag = "R7";
    step(1, 0, 0, 0, 0, 0, 0, 1, 2);
    for (int f = 0; f < 17; f++) begin
      step(1); step(1, f % 2 == 0); step(1); step(1, 0, 1);
    end

    // R8: four fields
    cur_tag = "R8";
    step(1, 0, 0, 0, 0, 0, 0, 1, 3);
    for (int f = 0; f < 10; f++) begin
      step(1); step(0); step(1, 0, 1);
    end

    // R9/R11: external clear only
    cur_tag = "R9";
    step(1, 0, 0, 0, 0, 0, 0, 1, 0);
    for (int f = 0; f < 10; f++) begin
      step(1, 1); step(1, 0, 1); step(1);
    end
    check("R9", "no periodic clear in schedule 00", phase == 32'h0 ? 32'h1 : 32'h0, 32'h0);
    step(1, 0, 0, 1);
    step(1); step(1);
    step(0, 1, 1, 1);
    step(1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule